// File: doc/BRIEF.md
# I2C Pin Software-Override Multiplexer

This block sits between an I2C engine's open-drain pull-down controls and the two bus pads, SCL and SDA. By default the engine owns both pads. A single mode bit hands both pads to software at once, which can then choose for each pad whether it is driven or only observed. Software changes a driven level only by writing ones to a raise register or a lower register, so no read-modify-write is needed. Software runs a bus recovery sequence this way, for example by clocking SCL while it watches SDA. The recovery sequence itself stays in software.

The pad levels pass through a two-flop synchronizer before they reach the register read port. Software can read them in either mode. The engine always receives the raw pad levels. In software mode each pad is driven open-drain: a low latch value with the pad set as an output pulls the line down, and every other case releases it. The register port is a simple single-cycle write strobe with a combinational read. Bit 0 of every register belongs to SCL and bit 1 belongs to SDA.

Top module: `i2c_pin_override`

## Requirements
- R1: After reset the mode is I2C (0), the direction register reads 0, the output latch reads 2'b11, and both pad pull-downs follow the engine.
- R2: Address 0 bit 0 selects the mode: 1 is software mode and 0 is I2C mode. A read of address 0 returns the mode in bit 0 and 0 in bit 1.
- R3: In I2C mode, pad_scl_oe equals eng_scl_oe and pad_sda_oe equals eng_sda_oe, whatever the direction register and the output latch hold.
- R4: Address 1 is the direction register. Bit 0 set makes SCL an output and bit 1 set makes SDA an output. It reads back as written.
- R5: A write to address 3 sets each latch bit whose write-data bit is 1. Latch bits whose write-data bit is 0 keep their value.
- R6: A write to address 4 clears each latch bit whose write-data bit is 1. Latch bits whose write-data bit is 0 keep their value.
- R7: A read of address 3 or address 4 returns the current output latch.
- R8: In software mode a pad pull-down is active exactly when that pad is an output and its latch bit is 0. A pad set as an input never pulls.
- R9: Address 2 returns the synchronized pad levels (bit 0 SCL, bit 1 SDA), in both modes. A change applied between two rising edges is visible after the second of the next two rising edges, and not after the first.
- R10: In the recovery setup (software mode, direction 2'b01), SCL toggles through the lower and raise registers while SDA stays released and its pad level remains readable.
- R11: eng_scl_in and eng_sda_in equal the raw pad levels in the same cycle, in both modes.
- R12: Writes to address 2 and to addresses 5 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 2 | Write data, bit 0 SCL, bit 1 SDA |
| reg_rdata | output | 2 | Combinational read data |
| eng_scl_oe | input | 1 | Engine SCL pull-down request |
| eng_sda_oe | input | 1 | Engine SDA pull-down request |
| eng_scl_in | output | 1 | Raw SCL level to the engine |
| eng_sda_in | output | 1 | Raw SDA level to the engine |
| pad_scl_in | input | 1 | SCL pad level |
| pad_sda_in | input | 1 | SDA pad level |
| pad_scl_oe | output | 1 | SCL pad pull-down enable |
| pad_sda_oe | output | 1 | SDA pad pull-down enable |

## Verification
A register write takes effect at the rising edge that samples the strobe. The pad pull-downs are combinational from the registers, so the bench checks them after that edge, at the next falling edge. Engine-to-pad and pad-to-engine paths are combinational and are checked one time step after the input changes. Synchronized levels are due after the second rising edge that follows a pad change. The bench checks just after the first edge, where it expects the old value, and again after the second, where it expects the new one.

// File: rtl/pinov_pkg.sv
package pinov_pkg;
  localparam int NPIN = 2;   // bit 0 SCL, bit 1 SDA
  localparam int AW   = 3;

  localparam logic [AW-1:0] A_MODE = 3'd0;
  localparam logic [AW-1:0] A_DIR  = 3'd1;
  localparam logic [AW-1:0] A_LVL  = 3'd2;
  localparam logic [AW-1:0] A_SET  = 3'd3;
  localparam logic [AW-1:0] A_CLR  = 3'd4;

  // open-drain pull request of one pad in software mode
  function automatic logic od_pull(input logic is_out, input logic lat_bit);
    return is_out & ~lat_bit;
  endfunction

  // latch after a raise write
  function automatic logic [NPIN-1:0] lat_raise(input logic [NPIN-1:0] lat,
                                                input logic [NPIN-1:0] msk);
    return lat | msk;
  endfunction

  // latch after a lower write
  function automatic logic [NPIN-1:0] lat_lower(input logic [NPIN-1:0] lat,
                                                input logic [NPIN-1:0] msk);
    return lat & ~msk;
  endfunction
endpackage

// File: rtl/pinov_regs.sv
module pinov_regs
  import pinov_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [NPIN-1:0] wdata,
  input  logic [NPIN-1:0] lvl,
  output logic [NPIN-1:0] rdata,
  output logic            mode_sw,
  output logic [NPIN-1:0] dir_out,
  output logic [NPIN-1:0] lat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_sw <= 1'b0;
      dir_out <= '0;
      lat     <= '1;
    end else if (we) begin
      case (addr)
        A_MODE:  mode_sw <= wdata[0];
        A_DIR:   dir_out <= wdata;
        A_SET:   lat     <= lat_raise(lat, wdata);
        A_CLR:   lat     <= lat_lower(lat, wdata);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_MODE:       rdata = {{(NPIN-1){1'b0}}, mode_sw};
      A_DIR:        rdata = dir_out;
      A_LVL:        rdata = lvl;
      A_SET, A_CLR: rdata = lat;
      default:      rdata = '0;
    endcase
  end

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_MODE) |=> (mode_sw == $past(wdata[0]))); // R2
  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_SET) |=> (((lat & $past(wdata)) == $past(wdata)) &&
      (((lat ^ $past(lat)) & ~$past(wdata)) == '0))); // R5
  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_CLR) |=> (((lat & $past(wdata)) == '0) &&
      (((lat ^ $past(lat)) & ~$past(wdata)) == '0))); // R6
  AST_DEAD_ADDR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (addr == A_LVL || addr > A_CLR)) |=>
      ($stable(mode_sw) && $stable(dir_out) && $stable(lat))); // R12
endmodule

// File: rtl/pinov_sync.sv
module pinov_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  localparam int CW = $clog2(STAGES + 1) + 1;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[i]};
    end
    assign synced[i] = chain[STAGES-1];

    // edges seen since the raw level last changed
    logic          raw_q;
    logic [CW-1:0] hold_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_q    <= 1'b1;
        hold_cnt <= '0;
      end else begin
        raw_q <= raw[i];
        if (raw[i] != raw_q)                 hold_cnt <= CW'(1);
        else if (hold_cnt < CW'(STAGES))     hold_cnt <= hold_cnt + 1'b1;
      end
    end

    AST_SYNC_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_cnt >= CW'(STAGES)) |-> (synced[i] == raw_q)); // R9
  end
endmodule

// File: rtl/pinov_drive.sv
module pinov_drive
  import pinov_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_sw,
  input  logic [NPIN-1:0] dir_out,
  input  logic [NPIN-1:0] lat,
  input  logic [NPIN-1:0] eng_oe,
  output logic [NPIN-1:0] pad_oe
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pad
    logic sw_pull;
    assign sw_pull   = od_pull(dir_out[i], lat[i]);
    assign pad_oe[i] = mode_sw ? sw_pull : eng_oe[i];

    AST_INPUT_NEVER_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sw && !dir_out[i]) |-> !pad_oe[i]); // R8
    AST_HIGH_LATCH_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sw && lat[i]) |-> !pad_oe[i]); // R8
  end
endmodule

// File: rtl/i2c_pin_override.sv
module i2c_pin_override
  import pinov_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [1:0]    reg_wdata,
  output logic [1:0]    reg_rdata,
  input  logic          eng_scl_oe,
  input  logic          eng_sda_oe,
  output logic          eng_scl_in,
  output logic          eng_sda_in,
  input  logic          pad_scl_in,
  input  logic          pad_sda_in,
  output logic          pad_scl_oe,
  output logic          pad_sda_oe
);
  logic [NPIN-1:0] pad_lvl_raw;
  logic [NPIN-1:0] pad_lvl_sync;
  logic [NPIN-1:0] eng_oe_vec;
  logic [NPIN-1:0] pad_oe_vec;
  logic            mode_sw;
  logic [NPIN-1:0] dir_out;
  logic [NPIN-1:0] lat;

  assign pad_lvl_raw = {pad_sda_in, pad_scl_in};
  assign eng_oe_vec  = {eng_sda_oe, eng_scl_oe};
  assign eng_scl_in  = pad_scl_in;
  assign eng_sda_in  = pad_sda_in;
  assign pad_scl_oe  = pad_oe_vec[0];
  assign pad_sda_oe  = pad_oe_vec[1];

  pinov_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .lvl     (pad_lvl_sync),
    .rdata   (reg_rdata),
    .mode_sw (mode_sw),
    .dir_out (dir_out),
    .lat     (lat)
  );

  pinov_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (pad_lvl_raw),
    .synced (pad_lvl_sync)
  );

  pinov_drive u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_sw (mode_sw),
    .dir_out (dir_out),
    .lat     (lat),
    .eng_oe  (eng_oe_vec),
    .pad_oe  (pad_oe_vec)
  );

  AST_ENGINE_OWNS_PADS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sw |-> (pad_scl_oe == eng_scl_oe && pad_sda_oe == eng_sda_oe)); // R3
  AST_ENGINE_SEES_PADS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_scl_in == pad_scl_in) && (eng_sda_in == pad_sda_in)); // R11
endmodule

// File: tb/sim_i2c_pin_override.sv
`timescale 1ns/1ps
module sim_i2c_pin_override;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [1:0] reg_wdata = 2'd0;
  logic [1:0] reg_rdata;
  logic eng_scl_oe = 1'b0, eng_sda_oe = 1'b0;
  logic eng_scl_in, eng_sda_in;
  logic pad_scl_in = 1'b1, pad_sda_in = 1'b1;
  logic pad_scl_oe, pad_sda_oe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  i2c_pin_override u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_scl_oe(eng_scl_oe), .eng_sda_oe(eng_sda_oe),
    .eng_scl_in(eng_scl_in), .eng_sda_in(eng_sda_in),
    .pad_scl_in(pad_scl_in), .pad_sda_in(pad_sda_in),
    .pad_scl_oe(pad_scl_oe), .pad_sda_oe(pad_sda_oe)
  );

  task automatic chk(input string req, input string what,
                     input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [1:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [1:0] oe_now();
    return {pad_sda_oe, pad_scl_oe};
  endfunction

  task automatic t_reset();
    logic [1:0] v;
    rd(3'd0, v); chk("R1", "mode", v, 2'b00);
    rd(3'd1, v); chk("R1", "dir", v, 2'b00);
    rd(3'd3, v); chk("R1", "latch", v, 2'b11);
    eng_scl_oe = 1'b1; eng_sda_oe = 1'b0; #1;
    chk("R1", "pads follow engine", oe_now(), 2'b01);
    eng_scl_oe = 1'b0; #1;
  endtask

  task automatic t_engine_pass();
    wr(3'd1, 2'b11); wr(3'd4, 2'b11);  // would pull both in software mode
    for (int k = 0; k < 4; k++) begin
      {eng_sda_oe, eng_scl_oe} = 2'(k); #1;
      chk("R3", "engine owns pads", oe_now(), 2'(k));
    end
    eng_scl_oe = 1'b0; eng_sda_oe = 1'b0;
    wr(3'd3, 2'b11); wr(3'd1, 2'b00);
  endtask

  task automatic t_mode_dir();
    logic [1:0] v;
    wr(3'd0, 2'b11); rd(3'd0, v); chk("R2", "mode on, bit1 zero", v, 2'b01);
    eng_scl_oe = 1'b1; eng_sda_oe = 1'b1; #1;
    chk("R2", "engine cut off", oe_now(), 2'b00);
    wr(3'd0, 2'b00); rd(3'd0, v); chk("R2", "mode off", v, 2'b00);
    #1 chk("R2", "engine back", oe_now(), 2'b11);
    eng_scl_oe = 1'b0; eng_sda_oe = 1'b0;
    wr(3'd1, 2'b10); rd(3'd1, v); chk("R4", "dir sda", v, 2'b10);
    wr(3'd1, 2'b01); rd(3'd1, v); chk("R4", "dir scl", v, 2'b01);
    wr(3'd1, 2'b00);
  endtask

  task automatic t_set_clr();
    logic [1:0] v;
    wr(3'd4, 2'b01); rd(3'd3, v); chk("R6", "lower scl only", v, 2'b10);
    wr(3'd4, 2'b00); rd(3'd4, v); chk("R6", "zero lower no effect", v, 2'b10);
    wr(3'd4, 2'b10); rd(3'd4, v); chk("R7", "read via lower addr", v, 2'b00);
    wr(3'd3, 2'b00); rd(3'd3, v); chk("R5", "zero raise no effect", v, 2'b00);
    wr(3'd3, 2'b10); rd(3'd3, v); chk("R5", "raise sda only", v, 2'b10);
    wr(3'd3, 2'b01); rd(3'd4, v); chk("R7", "latch full", v, 2'b11);
  endtask

  task automatic t_open_drain();
    wr(3'd0, 2'b01);
    wr(3'd4, 2'b11);
    wr(3'd1, 2'b00); #1 chk("R8", "inputs never pull", oe_now(), 2'b00);
    wr(3'd1, 2'b10); #1 chk("R8", "sda out low pulls", oe_now(), 2'b10);
    wr(3'd1, 2'b11); #1 chk("R8", "both out low pull", oe_now(), 2'b11);
    wr(3'd3, 2'b01); #1 chk("R8", "scl high releases", oe_now(), 2'b10);
    wr(3'd3, 2'b10); wr(3'd1, 2'b00); wr(3'd0, 2'b00);
  endtask

  task automatic t_sync();
    logic [1:0] v;
    @(negedge clk); pad_scl_in = 1'b0; pad_sda_in = 1'b1;
    #1 chk("R11", "engine sees raw", {eng_sda_in, eng_scl_in}, 2'b10);
    @(posedge clk); #1 rd(3'd2, v); chk("R9", "not after first edge", v, 2'b11);
    @(posedge clk); #1 rd(3'd2, v); chk("R9", "after second edge", v, 2'b10);
    wr(3'd0, 2'b01);
    @(negedge clk); pad_sda_in = 1'b0;
    #1 chk("R11", "engine sees raw sw mode", {eng_sda_in, eng_scl_in}, 2'b00);
    @(posedge clk); @(posedge clk); #1 rd(3'd2, v);
    chk("R9", "levels in sw mode", v, 2'b00);
    @(negedge clk); pad_scl_in = 1'b1; pad_sda_in = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    wr(3'd0, 2'b00);
  endtask

  task automatic t_recovery();
    logic [1:0] v;
    wr(3'd0, 2'b01); wr(3'd1, 2'b01);
    pad_sda_in = 1'b0;  // stuck target holds SDA
    for (int k = 0; k < 3; k++) begin
      wr(3'd4, 2'b01); #1 chk("R10", "scl pulled", oe_now(), 2'b01);
      wr(3'd3, 2'b01); #1 chk("R10", "scl released", oe_now(), 2'b00);
    end
    rd(3'd2, v); chk("R10", "sda level visible", v, 2'b01);
    pad_sda_in = 1'b1;
    wr(3'd1, 2'b00); wr(3'd0, 2'b00);
  endtask

  task automatic t_ignored();
    logic [1:0] v;
    wr(3'd2, 2'b11);
    for (int a = 5; a < 8; a++) wr(3'(a), 2'b11);
    rd(3'd0, v); chk("R12", "mode kept", v, 2'b00);
    rd(3'd1, v); chk("R12", "dir kept", v, 2'b00);
    rd(3'd3, v); chk("R12", "latch kept", v, 2'b11);
    eng_scl_oe = 1'b1; #1 chk("R12", "pads still engine", oe_now(), 2'b01);
    eng_scl_oe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_engine_pass();
    t_mode_dir();
    t_set_clr();
    t_open_drain();
    t_sync();
    t_recovery();
    t_ignored();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule